// File: doc/BRIEF.md
# Standby Power Mode Controller

This block owns one byte-wide standby control register on the register bus and a power-state machine that turns the register's request bits into clock and oscillator enables. Software asks for light sleep, where only the processor clock halts, or deep stop, where every internal clock halts. A third register bit decides whether the main oscillator, and the PLL fed by it, also shut down during stop. Any asserted wake source ends a standby state. The controller then brings the oscillator and PLL back first and restores the processor and peripheral clocks only after a fixed settle time.

An optional synchronous entry, selected by an input, holds a standby request until software has read the register back after the write. This lets a processor finish its outstanding bus traffic before the clocks are cut. A wake source that is present while a request is pending cancels the request.

States: `ST_RUN` (code 0), `ST_ARMED` (1), `ST_SLEEP` (2), `ST_STOP` (3) and `ST_SETTLE` (4). Transitions:
- run to stop or sleep on an accepted request write;
- run to armed when synchronous entry is on;
- armed to stop or sleep on a read-back;
- armed to run on a wake;
- stop or sleep to settle on a wake;
- settle to run when the settle count has elapsed.

Top module: `stby_ctrl`

## Requirements
- R1: The register answers only at byte address REG_ADDR (default 0x481). A read there returns bit 7 = stop request, bit 6 = sleep request and bit 0 = oscillator-off, with all other bits 0. A read at any other address returns 0, and a write at any other address changes nothing.
- R2: With synchronous entry off, a write in run with bit 7 set moves `pwr_state` to 3 (stop) at the next clock edge. In stop, `cpu_clk_en` and `periph_clk_en` are 0.
- R3: A write in run with bit 6 set and bit 7 clear moves `pwr_state` to 2 (sleep). In sleep only `cpu_clk_en` is 0, and `periph_clk_en` and `osc_en` stay 1.
- R4: A write with bits 7 and 6 both set enters stop, not sleep.
- R5: In stop, `osc_en` is 0 when the oscillator-off bit is 1 and stays 1 when that bit is 0. In every other state `osc_en` is 1.
- R6: `pll_en` follows `pll_en_in`, except in stop with the oscillator-off bit at 1, where it is 0.
- R7: Stop and sleep are held for as long as no `wake_req` bit is high.
- R8: When any `wake_req` bit is high in stop or sleep, the controller enters settle (4) and the stop and sleep bits read back as 0. Settle lasts SETTLE_CYC cycles with `osc_en` = 1, `pll_en` = `pll_en_in` and both clock enables at 0. The controller then returns to run (0) with all enables restored.
- R9: With `sync_mode` high, a request write moves the controller to armed (1), which keeps every enable at its run value. The controller leaves armed for stop or sleep only on a read of the register.
- R10: A wake source that is high in the same cycle as a request write, or at any time while armed, cancels entry. The controller stays in or returns to run, and the stop and sleep bits are cleared.
- R11: Register writes are accepted only in run. Writes in armed, sleep, stop or settle leave all three bits unchanged. Wake sources in run and in settle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register bus byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 unless a read hits |
| sync_mode | input | 1 | Selects synchronous entry via read-back |
| pll_en_in | input | 1 | PLL enable from the clock-source register |
| wake_req | input | WAKE_W | Wake sources, any bit high wakes |
| cpu_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Main oscillator enable |
| pll_en | output | 1 | Main PLL enable |
| pwr_state | output | 3 | State code: 0 run, 1 armed, 2 sleep, 3 stop, 4 settle |

## Verification
The bench builds the controller with SETTLE_CYC = 4 and WAKE_W = 3. The short settle window lets every wake be followed through settle back to run within a few cycles, so the first and last settle cycles are compared exactly. Three wake lines allow wakes on different bits, plus a wake held into settle, where it must have no effect. The default address is kept, so the reads and writes aimed at nearby addresses check the exact decode.

// File: rtl/stby_pkg.sv
package stby_pkg;
    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_ARMED  = 3'd1,
        ST_SLEEP  = 3'd2,
        ST_STOP   = 3'd3,
        ST_SETTLE = 3'd4
    } pwr_state_t;

    localparam int BIT_STOP   = 7;
    localparam int BIT_SLEEP  = 6;
    localparam int BIT_OSCOFF = 0;
endpackage

// File: rtl/stby_regif.sv
module stby_regif #(
    parameter int          ADDR_W   = 12,
    parameter logic [11:0] REG_ADDR = 12'h481
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    input  logic              wr_allow,
    input  logic              wake_any,
    output logic              wr_hit,
    output logic              rd_hit,
    output logic [7:0]        bus_rdata,
    output logic              req_stop,
    output logic              req_sleep,
    output logic              osc_off
);
    import stby_pkg::*;

    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

    logic sel;

    assign sel    = (bus_addr == MY_ADDR);
    assign wr_hit = bus_wr && sel && wr_allow;
    assign rd_hit = bus_rd && sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_stop  <= 1'b0;
            req_sleep <= 1'b0;
            osc_off   <= 1'b0;
        end else begin
            if (wr_hit) begin
                osc_off   <= bus_wdata[BIT_OSCOFF];
                req_stop  <= bus_wdata[BIT_STOP];
                req_sleep <= bus_wdata[BIT_SLEEP];
            end
            if (wake_any) begin
                req_stop  <= 1'b0;
                req_sleep <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (rd_hit) begin
            bus_rdata[BIT_STOP]   = req_stop;
            bus_rdata[BIT_SLEEP]  = req_sleep;
            bus_rdata[BIT_OSCOFF] = osc_off;
        end
    end
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm #(
    parameter int SETTLE_CYC = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_hit,
    input  logic                 wd_stop,
    input  logic                 wd_sleep,
    input  logic                 rd_hit,
    input  logic                 req_stop,
    input  logic                 sync_mode,
    input  logic                 wake_any,
    output stby_pkg::pwr_state_t state
);
    import stby_pkg::*;

    localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

    pwr_state_t       nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             wants_standby;

    assign wants_standby = wr_hit && (wd_stop || wd_sleep);

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            ST_RUN: begin
                if (wants_standby && !wake_any) begin
                    if (sync_mode)    nxt = ST_ARMED;
                    else if (wd_stop) nxt = ST_STOP;
                    else              nxt = ST_SLEEP;
                end
            end
            ST_ARMED: begin
                if (wake_any)      nxt = ST_RUN;
                else if (rd_hit)   nxt = req_stop ? ST_STOP : ST_SLEEP;
            end
            ST_SLEEP, ST_STOP: begin
                if (wake_any) begin
                    nxt     = ST_SETTLE;
                    cnt_nxt = '0;
                end
            end
            ST_SETTLE: begin
                if (cnt == CNT_LAST) nxt = ST_RUN;
                else                 cnt_nxt = cnt + 1'b1;
            end
            default: nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end
endmodule

// File: rtl/stby_clkgate.sv
module stby_clkgate (
    input  stby_pkg::pwr_state_t state,
    input  logic                 osc_off,
    input  logic                 pll_en_in,
    output logic                 cpu_clk_en,
    output logic                 periph_clk_en,
    output logic                 osc_en,
    output logic                 pll_en
);
    import stby_pkg::*;

    always_comb begin
        cpu_clk_en    = 1'b1;
        periph_clk_en = 1'b1;
        osc_en        = 1'b1;
        pll_en        = pll_en_in;
        unique case (state)
            ST_RUN, ST_ARMED: ;
            ST_SLEEP: cpu_clk_en = 1'b0;
            ST_STOP: begin
                cpu_clk_en    = 1'b0;
                periph_clk_en = 1'b0;
                osc_en        = !osc_off;
                pll_en        = pll_en_in && !osc_off;
            end
            ST_SETTLE: begin
                cpu_clk_en    = 1'b0;
                periph_clk_en = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl #(
    parameter int          ADDR_W     = 12,
    parameter logic [11:0] REG_ADDR   = 12'h481,
    parameter int          WAKE_W     = 4,
    parameter int          SETTLE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              sync_mode,
    input  logic              pll_en_in,
    input  logic [WAKE_W-1:0] wake_req,
    output logic              cpu_clk_en,
    output logic              periph_clk_en,
    output logic              osc_en,
    output logic              pll_en,
    output logic [2:0]        pwr_state
);
    import stby_pkg::*;

    pwr_state_t state;
    logic wake_any, wr_hit, rd_hit, req_stop, req_sleep, osc_off, wr_allow;

    assign wake_any  = |wake_req;
    assign wr_allow  = (state == ST_RUN);
    assign pwr_state = state;

    stby_regif #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regif (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .wr_allow(wr_allow),
        .wake_any(wake_any), .wr_hit(wr_hit), .rd_hit(rd_hit),
        .bus_rdata(bus_rdata), .req_stop(req_stop), .req_sleep(req_sleep),
        .osc_off(osc_off)
    );

    stby_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit),
        .wd_stop(bus_wdata[BIT_STOP]), .wd_sleep(bus_wdata[BIT_SLEEP]),
        .rd_hit(rd_hit), .req_stop(req_stop), .sync_mode(sync_mode),
        .wake_any(wake_any), .state(state)
    );

    stby_clkgate u_gate (
        .state(state), .osc_off(osc_off), .pll_en_in(pll_en_in),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .osc_en(osc_en), .pll_en(pll_en)
    );
endmodule

// File: rtl/stby_ctrl_chk.sv
module stby_ctrl_chk #(
    parameter int SETTLE_CYC = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] st,
    input logic       wake_any,
    input logic       rd_hit,
    input logic       osc_off,
    input logic       pll_en_in,
    input logic       cpu_clk_en,
    input logic       periph_clk_en,
    input logic       osc_en,
    input logic       pll_en
);
    int settle_run;

    always_ff @(posedge clk) begin
        if (!rst_n)          settle_run <= 0;
        else if (st == 3'd4) settle_run <= settle_run + 1;
        else                 settle_run <= 0;
    end

    // R2
    a_r2_stop_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd3) |-> (!cpu_clk_en && !periph_clk_en));
    // R3
    a_r3_sleep_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd2) |-> (!cpu_clk_en && periph_clk_en && osc_en));
    // R6
    a_r6_pll_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (st != 3'd3) |-> (pll_en == pll_en_in));
    // R7
    a_r7_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == 3'd3 || st == 3'd2) && !wake_any) |=> (st == $past(st)));
    // R8
    a_r8_wake_settle: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == 3'd3 || st == 3'd2) && wake_any) |=> (st == 3'd4));
    a_r8_settle_len: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd4) |-> (settle_run < SETTLE_CYC));
    a_r8_settle_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd4 && settle_run == SETTLE_CYC - 1) |=> (st == 3'd0));
    // R9
    a_r9_armed_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd1 && !rd_hit && !wake_any) |=> (st == 3'd1));
    // R10
    a_r10_armed_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd1 && wake_any) |=> (st == 3'd0));
    // R11
    a_r11_osc_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (st != 3'd0) |=> $stable(osc_off));
endmodule

bind stby_ctrl stby_ctrl_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(pwr_state), .wake_any(wake_any),
    .rd_hit(rd_hit), .osc_off(osc_off), .pll_en_in(pll_en_in),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .osc_en(osc_en), .pll_en(pll_en)
);

// File: tb/sim_stby_ctrl.sv
`timescale 1ns/1ps
module sim_stby_ctrl;
    localparam int ADDR_W = 12;
    localparam int WK     = 3;
    localparam int SC     = 4;
    localparam logic [11:0] RA = 12'h481;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic sync_mode = 1'b0, pll_en_in = 1'b1;
    logic [WK-1:0] wake_req = '0;
    logic cpu_clk_en, periph_clk_en, osc_en, pll_en;
    logic [2:0] pwr_state;

    int checks = 0, errors = 0;
    bit done = 0;

    // behavioural reference state
    int m_st = 0, m_cnt = 0;
    bit m_stop = 0, m_sleep = 0, m_osc = 0;

    always #2.5 clk = ~clk;

    stby_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(RA), .WAKE_W(WK), .SETTLE_CYC(SC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sync_mode(sync_mode), .pll_en_in(pll_en_in), .wake_req(wake_req),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .osc_en(osc_en), .pll_en(pll_en), .pwr_state(pwr_state)
    );

    function automatic logic [7:0] exp_rd(bit rd, logic [11:0] a);
        if (rd && a == RA) return {m_stop, m_sleep, 5'b0, m_osc};
        return 8'h00;
    endfunction

    task automatic check_outs(string tag);
        logic [6:0] got, exp;
        bit c = 1, p = 1, o = 1, l = pll_en_in;
        if (m_st == 2) c = 0;
        if (m_st == 3) begin c = 0; p = 0; o = !m_osc; l = pll_en_in && !m_osc; end
        if (m_st == 4) begin c = 0; p = 0; end
        got = {pwr_state, cpu_clk_en, periph_clk_en, osc_en, pll_en};
        exp = {3'(m_st), c, p, o, l};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: state/cpu/per/osc/pll got %b expected %b", tag, got, exp);
        end
    endtask

    // one clock: drive at negedge, check read data, model the edge, check outputs
    task automatic cyc(string tag, bit wr, bit rd, logic [11:0] a, logic [7:0] wd, logic [WK-1:0] wk);
        bit wake, hit_w, hit_r;
        logic [7:0] er;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd; wake_req = wk;
        #1;
        er = exp_rd(rd, a);
        checks++;
        if (bus_rdata !== er) begin
            errors++;
            $display("FAIL %s (R1): rdata got %h expected %h", tag, bus_rdata, er);
        end
        wake  = (wk != 0);
        hit_w = wr && (a == RA) && (m_st == 0);
        hit_r = rd && (a == RA);
        case (m_st)
            0: if (hit_w) begin
                m_osc = wd[0]; m_stop = wd[7]; m_sleep = wd[6];
                if ((wd[7] || wd[6]) && !wake) m_st = sync_mode ? 1 : (wd[7] ? 3 : 2);
            end
            1: if (wake) m_st = 0;
               else if (hit_r) m_st = m_stop ? 3 : 2;
            2, 3: if (wake) begin m_st = 4; m_cnt = 0; end
            4: if (m_cnt == SC - 1) m_st = 0; else m_cnt++;
            default: ;
        endcase
        if (wake) begin m_stop = 0; m_sleep = 0; end
        @(posedge clk);
        @(negedge clk);
        check_outs(tag);
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) cyc(tag, 0, 0, 12'h000, 8'h00, '0);
    endtask
    task automatic wr_reg(string tag, logic [7:0] d);
        cyc(tag, 1, 0, RA, d, '0);
    endtask
    task automatic rd_reg(string tag);
        cyc(tag, 0, 1, RA, 8'h00, '0);
    endtask
    task automatic wake(string tag, logic [WK-1:0] w);
        cyc(tag, 0, 0, 12'h000, 8'h00, w);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_outs("R1 reset state");
        rd_reg("R1 reset read");
        // R1 decode
        wr_reg("R1 osc bit write", 8'h01);
        rd_reg("R1 readback osc");
        cyc("R1 write other addr", 1, 0, 12'h480, 8'hC1, '0);
        cyc("R1 write other addr", 1, 0, 12'h482, 8'hFF, '0);
        cyc("R1 read other addr", 0, 1, 12'h482, 8'h00, '0);
        wr_reg("R1 unused bits", 8'h3F);
        rd_reg("R1 unused read 0");
        // R2 R5 R6 stop with oscillator off
        wr_reg("R2 stop osc off", 8'h81);
        idle("R7 hold stop", 5);
        wr_reg("R11 write in stop", 8'h00);
        rd_reg("R11 read in stop");
        wake("R8 wake bit0", 3'b001);
        idle("R8 settle", 1);
        wake("R11 wake in settle", 3'b100);
        idle("R8 settle end", SC);
        rd_reg("R8 bits cleared");
        // R5 R6 stop with oscillator kept
        wr_reg("R5 stop osc on", 8'h80);
        idle("R6 pll alive", 2);
        pll_en_in = 1'b0;
        idle("R6 pll input low", 2);
        pll_en_in = 1'b1;
        wake("R8 wake bit2", 3'b100);
        idle("R8 settle", SC + 1);
        // R3 sleep
        wr_reg("R3 sleep", 8'h41);
        idle("R7 hold sleep", 4);
        wake("R8 sleep wake", 3'b010);
        idle("R8 settle", SC + 1);
        // R4 both bits
        wr_reg("R4 both set", 8'hC0);
        rd_reg("R4 readback");
        wake("R8 wake", 3'b001);
        idle("R8 settle", SC + 1);
        // R9 synchronous entry
        sync_mode = 1'b1;
        wr_reg("R9 armed stop", 8'h81);
        idle("R9 wait", 3);
        wr_reg("R11 write in armed", 8'h00);
        cyc("R9 read other addr", 0, 1, 12'h480, 8'h00, '0);
        rd_reg("R9 readback enters");
        idle("R9 stop", 2);
        wake("R8 wake", 3'b010);
        idle("R8 settle", SC + 1);
        wr_reg("R9 armed sleep", 8'h40);
        rd_reg("R9 sleep entry");
        wake("R8 wake", 3'b001);
        idle("R8 settle", SC + 1);
        // R10 abort cases
        wr_reg("R10 armed", 8'h80);
        idle("R10 armed", 1);
        wake("R10 wake while armed", 3'b010);
        rd_reg("R10 bits cleared");
        cyc("R10 read and wake", 1, 0, RA, 8'h80, '0);
        cyc("R10 read and wake", 0, 1, RA, 8'h00, 3'b001);
        sync_mode = 1'b0;
        cyc("R10 write with wake", 1, 0, RA, 8'h80, 3'b100);
        rd_reg("R10 write with wake read");
        idle("R11 wake in run", 1);
        wake("R11 wake in run", 3'b111);
        pll_en_in = 1'b0;
        idle("R6 run pll off", 2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule